// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully-associative store of lines recently thrown out of a direct-mapped cache. The main-cache controller consults it only after its own lookup misses. It presents the requested block address together with the line that the direct-mapped set would give up (address, dirty flag, data, and whether such a line exists). The buffer searches all of its entries at once. On a match it returns the stored line, which goes into the main cache. The line given up by the main cache takes over the freed slot, so the two lines trade places and the next level is not touched. When neither structure holds the block, the buffer raises a next-level request. The outgoing main-cache line then enters the buffer in first-in-first-out order. When the entry it displaces is valid and dirty, the buffer pulses a write-back strobe carrying that entry's address and data.

A request is accepted in one cycle. It is searched in the next cycle and answered in the cycle after that, so a victim hit costs one cycle more than a main-cache hit. The controller keeps its main arrays and drives the fill and refill paths itself.

The block is built around a four-state machine:
- `ST_IDLE` waits for a request.
- `ST_PROBE` compares the captured address against every entry.
- `ST_SWAP` answers a hit and rewrites the matching slot.
- `ST_FILL` raises the miss and inserts the outgoing line.

The transitions are: accept (`ST_IDLE` to `ST_PROBE` on `req_valid`), hit (`ST_PROBE` to `ST_SWAP`), miss (`ST_PROBE` to `ST_FILL`), and done (`ST_SWAP` or `ST_FILL` back to `ST_IDLE`).

Top module: `vc_victim_buffer`

## Requirements
- R1: After reset every entry is invalid, `ready` is 1, and `hit_valid`, `miss_req` and `wb_valid` are 0, so the first lookup of any address misses.
- R2: A request is taken only while `ready` is 1. `ready` is 0 for the two cycles after acceptance. The answer (`hit_valid` or `miss_req`, exactly one of them) is shown for one cycle, two clock edges after the accepting edge.
- R3: A lookup whose address matches no valid entry raises `miss_req` with `miss_addr` equal to the requested address and leaves `hit_valid` at 0.
- R4: A lookup whose address matches a valid entry raises `hit_valid` with that entry's stored data and dirty flag, and leaves `miss_req` at 0.
- R5: On a hit with an outgoing line present, the matching slot is overwritten with the outgoing line (swap). The old address then misses, and the outgoing address hits with its own data and dirty flag.
- R6: On a hit with no outgoing line, the matching slot becomes invalid.
- R7: On a miss with an outgoing line, that line is written into the slot named by a rotating insertion pointer, which starts at slot 0 after reset and advances by one (modulo the depth). The fifth insertion into a four-entry buffer therefore replaces the first.
- R8: When an insertion displaces a valid dirty entry, `wb_valid` pulses in the same cycle as `miss_req`, with `wb_addr` and `wb_data` equal to the displaced entry's address and data. A clean or invalid displaced entry gives no pulse.
- R9: A miss with no outgoing line changes no entry and does not move the insertion pointer.
- R10: A swap does not move the insertion pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request after a main-cache miss |
| req_addr | input | ADDR_W | Block address (tag and index) being looked up |
| out_valid | input | 1 | The main-cache set holds a line that it gives up |
| out_addr | input | ADDR_W | Block address of the outgoing main-cache line |
| out_dirty | input | 1 | Outgoing line is modified |
| out_data | input | DATA_W | Outgoing line contents |
| ready | output | 1 | Buffer can accept a request |
| hit_valid | output | 1 | Victim hit; line supplied to the main cache |
| hit_data | output | DATA_W | Line returned on a hit |
| hit_dirty | output | 1 | Dirty flag of the returned line |
| miss_req | output | 1 | Next-level read request |
| miss_addr | output | ADDR_W | Address for the next-level read |
| wb_valid | output | 1 | Dirty displaced entry must be written back |
| wb_addr | output | ADDR_W | Address of the written-back entry |
| wb_data | output | DATA_W | Data of the written-back entry |

## Verification
The assertions assume that the buffer never holds two valid entries with the same address. They also assume that an outgoing main-cache line is never already in the buffer and never equals the requested address, since a real direct-mapped cache and its victim store are disjoint. The bench keeps a reference copy of the buffer contents. Before each request it drops the outgoing line (by clearing `out_valid`) whenever that line's address is already held or equals the lookup address, so every stimulus respects this rule. The request inputs are held only during the accepting cycle, which matches the assumption that they are sampled at acceptance alone.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_SWAP  = 2'd2,
        ST_FILL  = 2'd3
    } vc_state_e;
endpackage

// File: rtl/vc_slot_store.sv
module vc_slot_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic                           wr_valid,
    input  logic                           wr_dirty,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic                           rd_valid,
    output logic                           rd_dirty,
    output logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [DEPTH-1:0]               all_valid,
    output logic [DEPTH-1:0][ADDR_W-1:0]   all_addr
);
    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0]             dirty_q;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                dirty_q[g] <= wr_dirty;
                addr_q[g]  <= wr_addr;
                data_q[g]  <= wr_data;
            end
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_dirty  = dirty_q[rd_idx];
    assign rd_addr   = addr_q[rd_idx];
    assign rd_data   = data_q[rd_idx];
    assign all_valid = valid_q;
    assign all_addr  = addr_q;
endmodule

// File: rtl/vc_match.sv
module vc_match #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [ADDR_W-1:0]             key,
    input  logic [DEPTH-1:0]              valid,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  addr,
    output logic [DEPTH-1:0]              match_vec,
    output logic                          any_match,
    output logic [IDX_W-1:0]              match_idx
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (addr[g] == key);
    end

    assign any_match = |match_vec;

    always_comb begin
        match_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_insert_ptr.sv
module vc_insert_ptr #(
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    assert_ptr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
endmodule

// File: rtl/vc_victim_buffer.sv
module vc_victim_buffer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              out_valid,
    input  logic [ADDR_W-1:0] out_addr,
    input  logic              out_dirty,
    input  logic [DATA_W-1:0] out_data,
    output logic              ready,
    output logic              hit_valid,
    output logic [DATA_W-1:0] hit_data,
    output logic              hit_dirty,
    output logic              miss_req,
    output logic [ADDR_W-1:0] miss_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    import vc_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    vc_state_e state_q, state_d;

    logic [ADDR_W-1:0] req_addr_q;
    logic              out_valid_q;
    logic [ADDR_W-1:0] out_addr_q;
    logic              out_dirty_q;
    logic [DATA_W-1:0] out_data_q;
    logic [IDX_W-1:0]  hit_idx_q;

    logic                          wr_en;
    logic [IDX_W-1:0]              wr_idx;
    logic                          wr_valid;
    logic [IDX_W-1:0]              rd_idx;
    logic                          rd_valid;
    logic                          rd_dirty;
    logic [ADDR_W-1:0]             rd_addr;
    logic [DATA_W-1:0]             rd_data;
    logic [DEPTH-1:0]              all_valid;
    logic [DEPTH-1:0][ADDR_W-1:0]  all_addr;
    logic [DEPTH-1:0]              match_vec;
    logic                          any_match;
    logic [IDX_W-1:0]              match_idx;
    logic                          advance;
    logic [IDX_W-1:0]              ins_ptr;

    vc_slot_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_dirty  (out_dirty_q),
        .wr_addr   (out_addr_q),
        .wr_data   (out_data_q),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .all_valid (all_valid),
        .all_addr  (all_addr)
    );

    vc_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
        .key       (req_addr_q),
        .valid     (all_valid),
        .addr      (all_addr),
        .match_vec (match_vec),
        .any_match (any_match),
        .match_idx (match_idx)
    );

    vc_insert_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .ptr     (ins_ptr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and hit slot capture
    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && req_valid) begin
            req_addr_q  <= req_addr;
            out_valid_q <= out_valid;
            out_addr_q  <= out_addr;
            out_dirty_q <= out_dirty;
            out_data_q  <= out_data;
        end
        if (state_q == ST_PROBE) begin
            hit_idx_q <= match_idx;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_PROBE;
            ST_PROBE: state_d = any_match ? ST_SWAP : ST_FILL;
            ST_SWAP:  state_d = ST_IDLE;
            ST_FILL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and store control
    always_comb begin
        ready     = 1'b0;
        hit_valid = 1'b0;
        miss_req  = 1'b0;
        wb_valid  = 1'b0;
        wr_en     = 1'b0;
        wr_valid  = 1'b0;
        wr_idx    = ins_ptr;
        rd_idx    = ins_ptr;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
            end
            ST_PROBE: begin
            end
            ST_SWAP: begin
                hit_valid = 1'b1;
                rd_idx    = hit_idx_q;
                wr_idx    = hit_idx_q;
                wr_en     = 1'b1;
                wr_valid  = out_valid_q;
            end
            ST_FILL: begin
                miss_req = 1'b1;
                if (out_valid_q) begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b1;
                    advance  = 1'b1;
                    wb_valid = rd_valid && rd_dirty;
                end
            end
            default: begin
            end
        endcase
    end

    assign hit_data  = rd_data;
    assign hit_dirty = rd_dirty;
    assign miss_addr = req_addr_q;
    assign wb_addr   = rd_addr;
    assign wb_data   = rd_data;

    assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE) |-> $onehot0(match_vec));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    assert_answer_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && ready, 2) |-> ((hit_valid || miss_req) && !(hit_valid && miss_req)));

    assert_wb_with_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (miss_req && out_valid_q));

    assert_swap_keeps_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> (ins_ptr == $past(ins_ptr)));

    assert_idle_after_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && !out_valid_q) |=> (ins_ptr == $past(ins_ptr)));
endmodule

// File: tb/test_vc_victim_buffer.sv
module test_vc_victim_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          out_valid = 1'b0;
    logic [AW-1:0] out_addr = '0;
    logic          out_dirty = 1'b0;
    logic [DW-1:0] out_data = '0;
    logic          ready, hit_valid, hit_dirty, miss_req, wb_valid;
    logic [DW-1:0] hit_data, wb_data;
    logic [AW-1:0] miss_addr, wb_addr;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic          m_valid [DP];
    logic          m_dirty [DP];
    logic [AW-1:0] m_addr  [DP];
    logic [DW-1:0] m_data  [DP];
    int            m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    vc_victim_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) i_vc_victim_buffer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_dirty(out_dirty),
        .out_data(out_data), .ready(ready), .hit_valid(hit_valid),
        .hit_data(hit_data), .hit_dirty(hit_dirty), .miss_req(miss_req),
        .miss_addr(miss_addr), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a, input int k);
        return DW'(a * 37 + k * 11 + 5);
    endfunction

    function automatic int find(input logic [AW-1:0] a);
        for (int i = 0; i < DP; i++) if (m_valid[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    // One lookup; tag names the requirement the outcome exercises.
    task automatic access(input logic [AW-1:0] a, input bit ov, input logic [AW-1:0] oa,
                          input bit od, input logic [DW-1:0] odat, input string tag);
        int  h;
        bit  ov_eff;
        ov_eff = ov && (find(oa) < 0) && (oa != a);
        h = find(a);
        req_valid = 1'b1; req_addr = a;
        out_valid = ov_eff; out_addr = oa; out_dirty = od; out_data = odat;
        chk(ready == 1'b1, "R2", "ready before accept", ready, 1);
        @(negedge clk);
        req_valid = 1'b0; out_valid = 1'b0;
        chk(ready == 1'b0 && !hit_valid && !miss_req, "R2", "busy while probing",
            {ready, hit_valid, miss_req}, 0);
        @(negedge clk);
        chk(ready == 1'b0, "R2", "busy while answering", ready, 0);
        if (h >= 0) begin
            chk(hit_valid && !miss_req, {tag, "/R4"}, "hit flags", {hit_valid, miss_req}, 2);
            chk(hit_data == m_data[h], {tag, "/R4"}, "hit data", hit_data, m_data[h]);
            chk(hit_dirty == m_dirty[h], {tag, "/R4"}, "hit dirty", hit_dirty, m_dirty[h]);
            chk(!wb_valid, "R8", "no write-back on hit", wb_valid, 0);
            m_valid[h] = ov_eff;
            if (ov_eff) begin
                m_addr[h] = oa; m_dirty[h] = od; m_data[h] = odat;
            end
        end else begin
            chk(miss_req && !hit_valid, {tag, "/R3"}, "miss flags", {miss_req, hit_valid}, 2);
            chk(miss_addr == a, {tag, "/R3"}, "miss addr", miss_addr, a);
            if (ov_eff && m_valid[m_ptr] && m_dirty[m_ptr]) begin
                chk(wb_valid == 1'b1, "R8", "write-back strobe", wb_valid, 1);
                chk(wb_addr == m_addr[m_ptr], "R8", "write-back addr", wb_addr, m_addr[m_ptr]);
                chk(wb_data == m_data[m_ptr], "R8", "write-back data", wb_data, m_data[m_ptr]);
            end else begin
                chk(wb_valid == 1'b0, "R8", "no write-back", wb_valid, 0);
            end
            if (ov_eff) begin
                m_valid[m_ptr] = 1'b1; m_addr[m_ptr] = oa;
                m_dirty[m_ptr] = od;   m_data[m_ptr] = odat;
                m_ptr = (m_ptr + 1) % DP;
            end
        end
        @(negedge clk);
        chk(ready == 1'b1 && !hit_valid && !miss_req && !wb_valid, "R2", "back to idle",
            {ready, hit_valid, miss_req, wb_valid}, 8);
    endtask

    initial begin
        for (int i = 0; i < DP; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_addr[i] = '0; m_data[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ready && !hit_valid && !miss_req && !wb_valid, "R1", "reset outputs",
            {ready, hit_valid, miss_req, wb_valid}, 8);
        for (int a = 0; a < 6; a++) access(AW'(a), 1'b0, '0, 1'b0, '0, "R1");
        // R9: misses with no outgoing line leave everything unchanged
        access(8'd40, 1'b0, 8'd0, 1'b0, '0, "R9");
        // R7: fill four slots, dirty on odd ones
        for (int k = 0; k < 4; k++)
            access(AW'(60 + k), 1'b1, AW'(10 + k), k[0], line_of(AW'(10 + k), k), "R7");
        // R4/R5: hit on 10, swap in 20
        access(8'd10, 1'b1, 8'd20, 1'b1, line_of(8'd20, 9), "R5");
        access(8'd20, 1'b1, 8'd21, 1'b0, line_of(8'd21, 3), "R5");
        access(8'd20, 1'b0, 8'd0, 1'b0, '0, "R5");
        // R6: hit without outgoing line invalidates
        access(8'd11, 1'b0, 8'd0, 1'b0, '0, "R6");
        access(8'd11, 1'b0, 8'd0, 1'b0, '0, "R6");
        // R10/R7/R8: insertions after swaps continue at the old pointer
        for (int k = 0; k < 6; k++)
            access(AW'(70 + k), 1'b1, AW'(30 + k), 1'b1, line_of(AW'(30 + k), k), "R10");
        access(8'd13, 1'b0, 8'd0, 1'b0, '0, "R7");
        // Sweep over a small address space
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] ra, oa;
            ra = AW'((i * 7) % 13);
            oa = AW'((i * 5 + 3) % 13);
            access(ra, (i % 5) != 0, oa, i[1], line_of(oa, i), "R7");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule